// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block runs one complete register transaction toward a 7-bit I2C target, for example a power-management device. A request carries a target address, a register index, a write byte and a direction flag. The sequencer drives a byte-level I2C master through single-cycle command strobes and watches that master's completion and fault flags. When the transaction finishes it returns a one-cycle `done` pulse. A read also returns the received byte. After the retries are used up it pulses `error` instead.

A write puts the address byte, the register index and the data byte on the bus and then closes with a stop. A read puts the address byte (write direction) and the register index on the bus. It then issues a repeated start and the address byte in the read direction. After that it switches the master to receive and takes one byte with a receive-mode stop. If arbitration is lost or the target does not acknowledge, the whole transaction is torn down and run again from its first step. The attempt count is bounded. A wait for the bus to go idle that never ends is treated as fatal. The sequencer also turns a 2-bit clock strap and an override pin into the SCL low and high period counts for the master.

Top module: `i2c_reg_seq`

## Requirements
- R1: A request (`req_valid` high while `idle` is high) is accepted, and `idle` is low in the following cycle. A `req_valid` pulse while the block is not idle is ignored: the transaction in flight and its bus commands are unchanged.
- R2: A write (`req_write`=1) issues these bus commands in order: start, send address byte, send register index, send data byte, stop, then disable once `st_busy` is low.
- R3: A read (`req_write`=0) issues these commands in order: start, send address byte, send register index, repeated start, send address byte, switch to receive, receive-with-stop, then disable once `st_busy` is low. `rdata` then holds the `rx_byte` value that the master presented with `st_dte`.
- R4: The address byte is the target address in bits 7..1, with bit 0 = 0 for the write direction and 1 for the read direction.
- R5: The first address byte of a phase (after start or repeated start) is sent only while `st_dte` is high. Every other step acts only while `st_wait` is high and clears that flag in the same cycle. At most one bus command is issued per cycle.
- R6: On `st_al` in any active step, the block clears the flag. If that step was the first address step, it also sends the filler byte 0x52. It then waits for `st_wait`, issues a stop while clearing wait, waits for `st_busy` low and disables the master.
- R7: On `st_nack` in any active step, the block issues a stop, masks the master's events and clears the flag in the same cycle. It then waits for `st_busy` low and disables the master.
- R8: Each abort restarts the transaction from start. The third abort of one request ends it with a one-cycle `error` pulse and no `done`. The abort count is cleared by each new request.
- R9: An abort raised in the receive-with-stop step of a read uses the receive-mode stop (`cmd_rx_stop`) instead of `cmd_stop`.
- R10: `done` is high for exactly one cycle, and `idle` is high in that same cycle. `rdata` keeps its value until a later successful read replaces it.
- R11: `strap_sel` picks the SCL low/high counts 00→7/1, 01→9/2, 10→11/3, 11→14/5. `strap_override` high forces 21/7.
- R12: If `st_busy` stays high for IDLE_WAIT cycles of a drain wait, `fatal` rises and stays high. No bus command is issued afterwards until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 7 | 7-bit target address |
| req_reg | input | 8 | Register index on the target |
| req_wdata | input | 8 | Byte to write |
| idle | output | 1 | Ready for a request |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle retries-exhausted pulse |
| fatal | output | 1 | Bus never went idle; sticky until reset |
| rdata | output | 8 | Last byte read |
| strap_sel | input | 2 | Clock strap |
| strap_override | input | 1 | Forces the alternate clock pair |
| scl_low | output | 8 | SCL low period count |
| scl_high | output | 8 | SCL high period count |
| st_wait | input | 1 | Master: byte step finished |
| st_dte | input | 1 | Master: transmit data empty / receive data ready |
| st_nack | input | 1 | Master: no acknowledge |
| st_al | input | 1 | Master: arbitration lost |
| st_busy | input | 1 | Master: bus busy |
| rx_byte | input | 8 | Master: received byte |
| cmd_start | output | 1 | Enable master and issue start |
| cmd_send | output | 1 | Load `tx_byte` for transmission |
| tx_byte | output | 8 | Byte to transmit |
| cmd_rstart | output | 1 | Repeated start |
| cmd_to_rx | output | 1 | Switch from send to receive |
| cmd_rx_stop | output | 1 | Receive-mode stop |
| cmd_stop | output | 1 | Normal stop |
| cmd_disable | output | 1 | Disable master |
| cmd_mask | output | 1 | Mask wait and data-empty events |
| clr_wait | output | 1 | Clear wait flag |
| clr_nack | output | 1 | Clear no-acknowledge flag |
| clr_al | output | 1 | Clear arbitration-lost flag |

## Verification
Commands and flag clears are combinational in the flags the sequencer samples. The master model in the bench therefore records each command at the same clock edge where the sequencer decides on it, and the command order is compared entry by entry. `idle` falls one cycle after acceptance. `done` or `error` rises one cycle after `st_busy` is seen low and is checked low again one cycle later. `fatal` is checked to rise exactly IDLE_WAIT cycles after the stop edge. All outputs are sampled on the falling edge, and the strap outputs are checked 1 ns after their inputs change.

// File: rtl/i2c_reg_seq.sv
`timescale 1ns/1ps
module i2c_reg_seq #(
  parameter int          RETRY_MAX  = 2,
  parameter int          IDLE_WAIT  = 1000,
  parameter logic [7:0]  DUMMY_BYTE = 8'h52
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [6:0] req_target,
  input  logic [7:0] req_reg,
  input  logic [7:0] req_wdata,
  output logic       idle,
  output logic       done,
  output logic       error,
  output logic       fatal,
  output logic [7:0] rdata,
  input  logic [1:0] strap_sel,
  input  logic       strap_override,
  output logic [7:0] scl_low,
  output logic [7:0] scl_high,
  input  logic       st_wait,
  input  logic       st_dte,
  input  logic       st_nack,
  input  logic       st_al,
  input  logic       st_busy,
  input  logic [7:0] rx_byte,
  output logic       cmd_start,
  output logic       cmd_send,
  output logic [7:0] tx_byte,
  output logic       cmd_rstart,
  output logic       cmd_to_rx,
  output logic       cmd_rx_stop,
  output logic       cmd_stop,
  output logic       cmd_disable,
  output logic       cmd_mask,
  output logic       clr_wait,
  output logic       clr_nack,
  output logic       clr_al
);
  localparam int EW = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;
  localparam int CW = $clog2(IDLE_WAIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR1, S_REG, S_DATA, S_STOP, S_RSTART, S_ADDR2,
    S_TORX, S_RXSTOP, S_RXCAP, S_DRAIN, S_AL_WAIT, S_ABORT, S_FATAL
  } st_t;

  st_t           state;
  logic          wr_q, abort_rx;
  logic [6:0]    tgt_q;
  logic [7:0]    reg_q, wd_q;
  logic [EW-1:0] errs;
  logic [CW-1:0] cnt;
  logic          chk, ok_w, ok_d;

  assign idle  = (state == S_IDLE);
  assign fatal = (state == S_FATAL);
  assign chk   = state inside {S_ADDR1, S_REG, S_DATA, S_STOP, S_RSTART,
                               S_ADDR2, S_TORX, S_RXSTOP};
  assign ok_w  = !st_al && !st_nack && st_wait;
  assign ok_d  = !st_al && !st_nack && st_dte;

  always_comb begin
    scl_low  = 8'd14;
    scl_high = 8'd5;
    case (strap_sel)
      2'b00: begin scl_low = 8'd7;  scl_high = 8'd1; end
      2'b01: begin scl_low = 8'd9;  scl_high = 8'd2; end
      2'b10: begin scl_low = 8'd11; scl_high = 8'd3; end
      default: ;
    endcase
    if (strap_override) begin
      scl_low  = 8'd21;
      scl_high = 8'd7;
    end
  end

  always_comb begin
    cmd_start = 1'b0; cmd_send = 1'b0; tx_byte = '0; cmd_rstart = 1'b0;
    cmd_to_rx = 1'b0; cmd_rx_stop = 1'b0; cmd_stop = 1'b0;
    cmd_disable = 1'b0; cmd_mask = 1'b0;
    clr_wait = 1'b0; clr_nack = 1'b0; clr_al = 1'b0;
    case (state)
      S_START:  cmd_start = 1'b1;
      S_ADDR1:  if (ok_d) begin cmd_send = 1'b1; tx_byte = {tgt_q, 1'b0}; end
      S_REG:    if (ok_w) begin cmd_send = 1'b1; tx_byte = reg_q; clr_wait = 1'b1; end
      S_DATA:   if (ok_w) begin cmd_send = 1'b1; tx_byte = wd_q;  clr_wait = 1'b1; end
      S_STOP:   if (ok_w) begin cmd_stop = 1'b1; clr_wait = 1'b1; end
      S_RSTART: if (ok_w) begin cmd_rstart = 1'b1; clr_wait = 1'b1; end
      S_ADDR2:  if (ok_d) begin cmd_send = 1'b1; tx_byte = {tgt_q, 1'b1}; end
      S_TORX:   if (ok_w) begin cmd_to_rx = 1'b1; clr_wait = 1'b1; end
      S_RXSTOP: if (ok_w) begin cmd_rx_stop = 1'b1; clr_wait = 1'b1; end
      S_AL_WAIT: if (st_wait) begin
        cmd_rx_stop = abort_rx;
        cmd_stop    = !abort_rx;
        clr_wait    = 1'b1;
      end
      S_DRAIN, S_ABORT: cmd_disable = !st_busy;
      default: ;
    endcase
    if (chk && st_al) begin
      clr_al = 1'b1;
      if (state == S_ADDR1) begin cmd_send = 1'b1; tx_byte = DUMMY_BYTE; end
    end else if (chk && st_nack) begin
      cmd_rx_stop = (state == S_RXSTOP);
      cmd_stop    = (state != S_RXSTOP);
      cmd_mask    = 1'b1;
      clr_nack    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; wr_q <= 1'b0; abort_rx <= 1'b0;
      tgt_q <= '0; reg_q <= '0; wd_q <= '0; errs <= '0; cnt <= '0;
      done <= 1'b0; error <= 1'b0; rdata <= '0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      cnt   <= '0;
      if (chk && st_al) begin
        abort_rx <= (state == S_RXSTOP);
        state    <= S_AL_WAIT;
      end else if (chk && st_nack) begin
        state <= S_ABORT;
      end else begin
        case (state)
          S_IDLE: if (req_valid) begin
            wr_q <= req_write; tgt_q <= req_target; reg_q <= req_reg;
            wd_q <= req_wdata; errs <= '0; state <= S_START;
          end
          S_START:   state <= S_ADDR1;
          S_ADDR1:   if (st_dte)  state <= S_REG;
          S_REG:     if (st_wait) state <= wr_q ? S_DATA : S_RSTART;
          S_DATA:    if (st_wait) state <= S_STOP;
          S_STOP:    if (st_wait) state <= S_DRAIN;
          S_RSTART:  if (st_wait) state <= S_ADDR2;
          S_ADDR2:   if (st_dte)  state <= S_TORX;
          S_TORX:    if (st_wait) state <= S_RXSTOP;
          S_RXSTOP:  if (st_wait) state <= S_RXCAP;
          S_RXCAP:   if (st_dte) begin rdata <= rx_byte; state <= S_DRAIN; end
          S_AL_WAIT: if (st_wait) state <= S_ABORT;
          S_DRAIN, S_ABORT: begin
            if (!st_busy) begin
              if (state == S_DRAIN) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else if (errs == EW'(RETRY_MAX)) begin
                error <= 1'b1;
                state <= S_IDLE;
              end else begin
                errs  <= errs + 1'b1;
                state <= S_START;
              end
            end else if (cnt == CW'(IDLE_WAIT - 1)) begin
              state <= S_FATAL;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_reg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       idle,
  input logic       done,
  input logic       error,
  input logic       fatal,
  input logic       st_wait,
  input logic       st_dte,
  input logic       st_al,
  input logic       st_nack,
  input logic       cmd_start,
  input logic       cmd_send,
  input logic       cmd_rstart,
  input logic       cmd_to_rx,
  input logic       cmd_rx_stop,
  input logic       cmd_stop,
  input logic       cmd_disable,
  input logic       cmd_mask
);
  logic cmd_any;
  assign cmd_any = cmd_start | cmd_send | cmd_rstart | cmd_to_rx | cmd_rx_stop |
                   cmd_stop | cmd_disable | cmd_mask;

  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid |=> !idle); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !cmd_any); // R1
  AST_ONE_BUS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_start, cmd_send, cmd_rstart, cmd_to_rx, cmd_rx_stop, cmd_stop}) <= 1); // R5
  AST_SEND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_send |-> (st_dte || st_wait || st_al)); // R5
  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mask |-> (st_nack && (cmd_stop || cmd_rx_stop))); // R7
  AST_DONE_XOR_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FATAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal && !cmd_any); // R12
endmodule

bind i2c_reg_seq i2c_reg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .idle(idle), .done(done),
  .error(error), .fatal(fatal), .st_wait(st_wait), .st_dte(st_dte),
  .st_al(st_al), .st_nack(st_nack), .cmd_start(cmd_start), .cmd_send(cmd_send),
  .cmd_rstart(cmd_rstart), .cmd_to_rx(cmd_to_rx), .cmd_rx_stop(cmd_rx_stop),
  .cmd_stop(cmd_stop), .cmd_disable(cmd_disable), .cmd_mask(cmd_mask)
);

// File: tb/i2c_reg_seq_test.sv
`timescale 1ns/1ps
module i2c_reg_seq_test;
  localparam int LIM = 40;
  localparam int K_START = 1, K_SEND = 2, K_RST = 3, K_TORX = 4, K_RXSTOP = 5,
                 K_STOP = 6, K_DIS = 7, K_MASK = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_target = '0;
  logic [7:0] req_reg = '0, req_wdata = '0;
  logic idle, done, error, fatal;
  logic [7:0] rdata, scl_low, scl_high, tx_byte, rx_byte;
  logic [1:0] strap_sel = 2'b00;
  logic strap_override = 1'b0;
  logic m_wait = 0, m_dte = 0, m_nack = 0, m_al = 0, m_busy = 0;
  logic cmd_start, cmd_send, cmd_rstart, cmd_to_rx, cmd_rx_stop, cmd_stop,
        cmd_disable, cmd_mask, clr_wait, clr_nack, clr_al;

  i2c_reg_seq #(.IDLE_WAIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .req_reg(req_reg), .req_wdata(req_wdata),
    .idle(idle), .done(done), .error(error), .fatal(fatal), .rdata(rdata),
    .strap_sel(strap_sel), .strap_override(strap_override),
    .scl_low(scl_low), .scl_high(scl_high),
    .st_wait(m_wait), .st_dte(m_dte), .st_nack(m_nack), .st_al(m_al),
    .st_busy(m_busy), .rx_byte(rx_byte),
    .cmd_start(cmd_start), .cmd_send(cmd_send), .tx_byte(tx_byte),
    .cmd_rstart(cmd_rstart), .cmd_to_rx(cmd_to_rx), .cmd_rx_stop(cmd_rx_stop),
    .cmd_stop(cmd_stop), .cmd_disable(cmd_disable), .cmd_mask(cmd_mask),
    .clr_wait(clr_wait), .clr_nack(clr_nack), .clr_al(clr_al)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] rx_val = '0;
  assign rx_byte = rx_val;

  // master model state
  int f_kind [0:2];
  int f_op   [0:2];
  int attempt = -1, op_idx = 0, pend_kind = 0, pend_cnt = 0, busy_cnt = 0;
  int viol = 0, cyc = 0, stop_cyc = 0, act_n = 0;
  bit faulted = 0, hang = 0;
  logic [11:0] act_log [0:63];
  logic [11:0] exp_log [0:63];
  int exp_n = 0;
  bit exp_err = 0;

  task automatic mlog(input int k, input logic [7:0] b);
    if (act_n < 64) act_log[act_n] = {k[3:0], b};
    act_n++;
  endtask

  task automatic issue(input int normal);
    int fk;
    fk = (attempt >= 0 && attempt < 3 && !faulted) ? f_kind[attempt] : 0;
    if (fk != 0 && f_op[attempt] == op_idx) begin
      pend_kind = (fk == 1) ? 3 : 4;
      faulted = 1;
    end else pend_kind = normal;
    pend_cnt = 3;
    op_idx++;
  endtask

  always @(posedge clk) begin
    logic w, d, n, a, b, anyf;
    cyc++;
    w = m_wait; d = m_dte; n = m_nack; a = m_al; b = m_busy;
    anyf = m_wait | m_dte | m_nack | m_al;
    if (!rst_n) begin
      w = 0; d = 0; n = 0; a = 0; b = 0; pend_kind = 0; busy_cnt = 0;
    end else begin
      if (clr_wait) w = 0;
      if (clr_nack) n = 0;
      if (clr_al) a = 0;
      if (pend_kind != 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          case (pend_kind)
            1: d = 1;
            2: w = 1;
            3: n = 1;
            default: begin a = 1; w = 1; end
          endcase
          pend_kind = 0;
        end
      end
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0 && !hang) b = 0;
      end
      if (cmd_send) begin
        if (!anyf) viol++;
        mlog(K_SEND, tx_byte); d = 0; issue(2);
      end
      if (cmd_start) begin
        mlog(K_START, 8'h00); attempt++; op_idx = 0; faulted = 0;
        w = 0; d = 0; b = 1; busy_cnt = 0; issue(1);
      end
      if (cmd_rstart) begin if (!anyf) viol++; mlog(K_RST, 8'h00); d = 0; issue(1); end
      if (cmd_to_rx)  begin if (!anyf) viol++; mlog(K_TORX, 8'h00); issue(2); end
      if (cmd_rx_stop) begin
        if (!anyf) viol++;
        mlog(K_RXSTOP, 8'h00); issue(1); busy_cnt = 6;
      end
      if (cmd_stop) begin
        if (!anyf) viol++;
        mlog(K_STOP, 8'h00); pend_kind = 0; busy_cnt = 6; stop_cyc = cyc;
      end
      if (cmd_mask) mlog(K_MASK, 8'h00);
      if (cmd_disable) mlog(K_DIS, 8'h00);
    end
    m_wait <= w; m_dte <= d; m_nack <= n; m_al <= a; m_busy <= b;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [7:0] b);
    if (exp_n < 64) exp_log[exp_n] = {k[3:0], b};
    exp_n++;
  endtask

  task automatic build_exp(input bit wr, input logic [6:0] t, input logic [7:0] r,
                           input logic [7:0] wd);
    logic [11:0] ops [0:6];
    int nops, k, sk;
    ops[0] = {4'(K_START), 8'h00};
    ops[1] = {4'(K_SEND), t, 1'b0};
    ops[2] = {4'(K_SEND), r};
    if (wr) begin
      ops[3] = {4'(K_SEND), wd}; nops = 4;
      ops[4] = '0; ops[5] = '0; ops[6] = '0;
    end else begin
      ops[3] = {4'(K_RST), 8'h00};
      ops[4] = {4'(K_SEND), t, 1'b1};
      ops[5] = {4'(K_TORX), 8'h00};
      ops[6] = {4'(K_RXSTOP), 8'h00};
      nops = 7;
    end
    exp_n = 0; exp_err = 1;
    for (int at = 0; at < 3; at++) begin
      if (f_kind[at] == 0) begin
        for (int i = 0; i < nops; i++) push(int'(ops[i][11:8]), ops[i][7:0]);
        if (wr) push(K_STOP, 8'h00);
        push(K_DIS, 8'h00);
        exp_err = 0;
        break;
      end
      k = f_op[at];
      for (int i = 0; i <= k; i++) push(int'(ops[i][11:8]), ops[i][7:0]);
      sk = (!wr && k == 5) ? K_RXSTOP : K_STOP;
      if (f_kind[at] == 2) begin
        if (k == 0) push(K_SEND, 8'h52);
        push(sk, 8'h00);
      end else begin
        push(sk, 8'h00);
        push(K_MASK, 8'h00);
      end
      push(K_DIS, 8'h00);
    end
  endtask

  logic [7:0] prev_rdata = '0;

  task automatic run_txn(input bit wr, input logic [6:0] t, input logic [7:0] r,
                         input logic [7:0] wd, input logic [7:0] rx, input string tag);
    int waited, bad;
    build_exp(wr, t, r, wd);
    act_n = 0; viol = 0; attempt = -1; rx_val = rx;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_target = t; req_reg = r; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(idle == 1'b0, "R1", "idle after accept", idle, 0);
    repeat (4) @(negedge clk);
    req_valid = 1; req_write = ~wr; req_target = ~t; req_reg = ~r; req_wdata = ~wd;
    @(negedge clk);
    req_valid = 0;
    waited = 0;
    while (!done && !error && !fatal && waited < 3000) begin
      @(negedge clk); waited++;
    end
    if (exp_err) chk(error && !done, "R8", "error outcome", {done, error}, 1);
    else         chk(done && !error, tag, "done outcome", {done, error}, 2);
    chk(idle == 1'b1, "R10", "idle with done", idle, 1);
    @(negedge clk);
    chk(!done && !error, "R10", "single-cycle pulse", {done, error}, 0);
    chk(act_n == exp_n, tag, "command count", act_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (bad < 0 && act_log[i] != exp_log[i]) bad = i;
    if (bad >= 0) chk(0, tag, "command order", act_log[bad], exp_log[bad]);
    else          chk(1, tag, "command order", 0, 0);
    chk(viol == 0, "R5", "command without flag", viol, 0);
    if (!wr && !exp_err) begin
      chk(rdata == rx, "R3", "read byte", rdata, rx);
      prev_rdata = rx;
    end else chk(rdata == prev_rdata, "R10", "rdata held", rdata, prev_rdata);
  endtask

  task automatic set_f(input int k0, input int o0, input int k1, input int o1,
                       input int k2, input int o2);
    f_kind[0] = k0; f_op[0] = o0;
    f_kind[1] = k1; f_op[1] = o1;
    f_kind[2] = k2; f_op[2] = o2;
  endtask

  function automatic logic [15:0] scl_exp(input logic [1:0] s, input logic ov);
    if (ov) return {8'd21, 8'd7};
    case (s)
      2'b00: return {8'd7, 8'd1};
      2'b01: return {8'd9, 8'd2};
      2'b10: return {8'd11, 8'd3};
      default: return {8'd14, 8'd5};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    set_f(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(idle && !done && !error && !fatal && rdata == 8'h00, "R1", "reset state",
        {idle, done, error, fatal}, 8);
    chk({cmd_start, cmd_send, cmd_stop, cmd_disable} == 4'b0, "R1", "reset quiet", 0, 0);
    rst_n = 1;
    @(negedge clk);

    for (int s = 0; s < 8; s++) begin
      logic [15:0] e;
      strap_sel = s[1:0]; strap_override = s[2];
      #1;
      e = scl_exp(s[1:0], s[2]);
      chk({scl_low, scl_high} == e, "R11", "scl counts", {scl_low, scl_high}, e);
    end
    strap_sel = 2'b00; strap_override = 0;

    set_f(0, 0, 0, 0, 0, 0);
    run_txn(1, 7'h2C, 8'h10, 8'h5A, 8'h00, "R2");
    run_txn(0, 7'h61, 8'h22, 8'h00, 8'hA5, "R3");
    run_txn(1, 7'h7F, 8'hFF, 8'h81, 8'h00, "R4");
    set_f(2, 0, 0, 0, 0, 0);
    run_txn(1, 7'h12, 8'h34, 8'h56, 8'h00, "R6");
    set_f(2, 4, 0, 0, 0, 0);
    run_txn(0, 7'h33, 8'h44, 8'h00, 8'h3C, "R6");
    set_f(1, 2, 0, 0, 0, 0);
    run_txn(1, 7'h45, 8'h01, 8'h02, 8'h00, "R7");
    set_f(1, 5, 0, 0, 0, 0);
    run_txn(0, 7'h0A, 8'h0B, 8'h00, 8'hC3, "R9");
    set_f(2, 5, 0, 0, 0, 0);
    run_txn(0, 7'h0C, 8'h0D, 8'h00, 8'h99, "R9");
    set_f(1, 1, 2, 3, 1, 0);
    run_txn(1, 7'h50, 8'h60, 8'h70, 8'h00, "R8");
    set_f(1, 1, 1, 3, 0, 0);
    run_txn(0, 7'h51, 8'h61, 8'h00, 8'h17, "R8");
    set_f(1, 1, 1, 2, 0, 0);
    run_txn(1, 7'h52, 8'h62, 8'h72, 8'h00, "R8");

    for (int n = 0; n < 24; n++) begin
      bit wr;
      wr = $urandom % 2;
      for (int a = 0; a < 3; a++) begin
        f_kind[a] = $urandom % 3;
        f_op[a] = $urandom % (wr ? 4 : 6);
      end
      run_txn(wr, 7'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              wr ? "R2" : "R3");
    end

    set_f(0, 0, 0, 0, 0, 0);
    hang = 1; act_n = 0; attempt = -1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_target = 7'h11; req_reg = 8'h22; req_wdata = 8'h33;
    @(negedge clk);
    req_valid = 0;
    begin
      int w2;
      w2 = 0;
      while (!fatal && w2 < 500) begin @(negedge clk); w2++; end
    end
    chk(fatal == 1'b1, "R12", "fatal raised", fatal, 1);
    chk(cyc - stop_cyc == LIM, "R12", "fatal latency", cyc - stop_cyc, LIM);
    begin
      int n0;
      n0 = act_n;
      repeat (10) @(negedge clk);
      chk(fatal == 1'b1 && act_n == n0, "R12", "fatal sticky and quiet", act_n, n0);
      chk(act_n == 5, "R12", "no disable after hang", act_n, 5);
    end
    hang = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(idle && !fatal, "R12", "cleared by reset", {idle, fatal}, 2);
    prev_rdata = 8'h00;
    run_txn(0, 7'h3A, 8'h4B, 8'h00, 8'h6E, "R3");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule